// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral on a small register bus: an address, a write strobe, write data and read data that is decoded from the address alone. Once software arms it, it counts its own clock cycles against a period of 2^(delay+1) cycles, where delay is a 5-bit field. Software keeps the system alive by writing two fixed 32-bit keys to two registers, in order. If the count runs out, if a refresh is malformed while the watchdog runs, or if software writes the soft-reset command, the block raises a system reset request. That request is a registered pulse of fixed length.

The block records why the last reset happened in a 3-bit cause code. The watchdog's own reset request does not clear this code; only the hard power-on reset does. An external user-reset input also sets the code. Software turns the watchdog off in two steps: it clears the enable bit, then it performs a valid refresh. Clearing the bit alone does not stop the watchdog.

Top module: `keyed_watchdog`

## Requirements
- R1: After the hard reset (`rst_n` low at a clock edge), `rst_req` is 0, the configuration reads 0, the cause reads 0, and no request appears however long the block then idles.
- R2: Configuration is at offset 0x4: bit 31 is the enable and bits [4:0] are the delay. The written value reads back at 0x4. Offset 0x8 reads the cause code in bits [2:0] with the other bits 0: 0 hard reset, 1 timeout, 2 bad refresh, 3 soft reset, 4 user reset.
- R3: A configuration write with bit 31 set while the watchdog is stopped starts it with that delay d. With no refresh, `rst_req` rises 2^(d+1) cycles after the write edge, and the cause becomes 1.
- R4: A valid refresh restarts the count from zero, so the next timeout follows 2^(d+1) cycles after the second key write. A valid refresh is 0xABCD1234 written to 0x8 and then 0x4321DCBA written to 0xC.
- R5: While the watchdog runs, each of these raises `rst_req` at the edge of the write and sets the cause to 2: a wrong value written to 0x8, a wrong value written to 0xC, or a correct 0xC write with no correct 0x8 write before it.
- R6: While the watchdog is stopped, key writes of any value raise no request and leave the cause unchanged.
- R7: Clearing bit 31 does not stop a running count. A valid refresh made after the bit is cleared stops the watchdog.
- R8: Writing a value with bit 0 set to offset 0x0 raises `rst_req` at the write edge and sets the cause to 3. A value with bit 0 clear has no effect.
- R9: `rst_req` stays high for exactly 16 cycles. During the pulse, triggers and bus writes are ignored and the cause is kept.
- R10: A request returns the watchdog to its stopped state with the configuration reading 0. The cause survives until the next hard reset.
- R11: A high cycle on `user_rst` sets the cause to 4 and stops the watchdog, without raising `rst_req`.
- R12: A delay written while the watchdog runs does not change the current period. It takes effect at the next valid refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | Hard power-on reset, synchronous, active low |
| user_rst | input | 1 | External user reset, synchronous, active high |
| bus_addr | input | 4 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | System reset request pulse |

## Verification
A counter that is off by one, or a delay that is latched at the wrong moment, moves the rising edge of `rst_req`. That edge is measured exactly, to the cycle, against 2^(delay+1) from the enabling write or from the refresh, so the fault shows within one timeout period. A fault in the key sequencer shows as a request one edge after a bad write, or as a missing request. It can also show as a stop that never takes effect, which turns up as a timeout within 2^(delay+1) cycles. A cause code that is wrong or is overwritten reads back wrongly at 0x8 right after the pulse. A pulse of the wrong length shows in the count of high cycles.

// File: rtl/kwdt_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 32-bit data path and byte offsets on the register bus.
package kwdt_pkg;
    localparam int DATA_W  = 32;
    localparam int DLY_W   = 5;
    localparam int CAUSE_W = 3;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'hABCD_1234;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h4321_DCBA;

    localparam int OFS_SOFT = 0;
    localparam int OFS_CFG  = 4;
    localparam int OFS_KEY1 = 8;
    localparam int OFS_KEY2 = 12;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_HARD    = 3'd0,
        CAUSE_TIMEOUT = 3'd1,
        CAUSE_BADKEY  = 3'd2,
        CAUSE_SOFT    = 3'd3,
        CAUSE_USER    = 3'd4
    } cause_e;
endpackage

// File: rtl/kwdt_keyseq.sv
// Refresh sequencer: tracks whether the first key has been written correctly,
// and flags a complete good refresh or a malformed key write.
// Assumes at most one of wr_first / wr_second is high in a cycle.
module kwdt_keyseq
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_first,
    input  logic              wr_second,
    input  logic [DATA_W-1:0] wdata,
    output logic              good,
    output logic              bad
);
    logic armed;

    // Classify the current key write.
    always_comb begin
        good = wr_second && armed && (wdata == KEY_SECOND);
        bad  = (wr_first && (wdata != KEY_FIRST)) || (wr_second && !good);
    end

    // Remember a correct first key until the next key write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   armed <= 1'b0;
        else if (wr_first)   armed <= (wdata == KEY_FIRST);
        else if (wr_second)  armed <= 1'b0;
    end

    // R4: arming only follows a correct first-key write
    a_r4_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_first && (wdata == KEY_FIRST)));
endmodule

// File: rtl/kwdt_period.sv
// Period counter: counts while running and flags expiry at 2^(delay+1)-1.
// Assumes the delay only changes together with a clear.
module kwdt_period #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DLY_W-1:0] delay,
    output logic             expire
);
    localparam int CNT_W = 1 << DLY_W;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;
    logic [DLY_W:0]   dly_p1;

    // Terminal count: low (delay+1) bits set.
    always_comb begin
        dly_p1 = {1'b0, delay} + 1'b1;
        limit  = ~({CNT_W{1'b1}} << dly_p1);
        expire = run && (count == limit);
    end

    // Advance the count while running, holding at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        count <= '0;
        else if (run && !expire)  count <= count + 1'b1;
    end

    // R3: a running count never passes its terminal value
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count <= limit));
endmodule

// File: rtl/kwdt_pulse.sv
// Reset-request pulse generator and cause register. A trigger starts a
// fixed-length pulse; triggers during the pulse are dropped.
// Assumes the trigger inputs are single-cycle qualified events.
module kwdt_pulse
    import kwdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               user_rst,
    input  logic               trig_soft,
    input  logic               trig_bad,
    input  logic               trig_tmo,
    output logic               req,
    output logic               fire,
    output logic [CAUSE_W-1:0] cause
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] pcnt;
    cause_e        cause_q;

    // Accept a trigger only when no pulse is in progress.
    always_comb fire = !req && (trig_soft || trig_bad || trig_tmo);

    // Hold the request high for PULSE_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            pcnt <= '0;
        end else if (fire) begin
            req  <= 1'b1;
            pcnt <= PW'(PULSE_LEN - 1);
        end else if (req) begin
            if (pcnt == '0) req <= 1'b0;
            else            pcnt <= pcnt - 1'b1;
        end
    end

    // Record the reason: user reset first, then soft, bad key, timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_q <= CAUSE_HARD;
        else if (user_rst) cause_q <= CAUSE_USER;
        else if (fire)     cause_q <= trig_soft ? CAUSE_SOFT :
                                      trig_bad  ? CAUSE_BADKEY : CAUSE_TIMEOUT;
    end

    assign cause = cause_q;

    // Checker: length of the current high stretch.
    logic [31:0] hi_len;
    always_ff @(posedge clk) begin
        if (!rst_n)   hi_len <= '0;
        else if (req) hi_len <= hi_len + 1'b1;
        else          hi_len <= '0;
    end

    // R9: pulse is exactly PULSE_LEN cycles
    a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (hi_len == 32'(PULSE_LEN)));
    // R9: cause is frozen during the pulse unless a user reset arrives
    a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !user_rst) |=> $stable(cause_q));
endmodule

// File: rtl/keyed_watchdog.sv
// Keyed watchdog top: register decode, enable/stop handshake, and wiring of
// the refresh sequencer, period counter and request pulse.
// Assumes one clock for bus and counter; reads are decoded from bus_addr.
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic               wr_ok, wr_soft, wr_cfg, wr_k1, wr_k2;
    logic               key_good, key_bad, expire, fire, start, state_clr;
    logic               cfg_en, run;
    logic [DLY_W-1:0]   cfg_dly, act_dly;
    logic [CAUSE_W-1:0] cause;

    // Decode bus writes; writes are dropped during a pulse or user reset.
    always_comb begin
        wr_ok     = bus_wr && !rst_req && !user_rst;
        wr_soft   = wr_ok && (bus_addr == ADDR_W'(OFS_SOFT));
        wr_cfg    = wr_ok && (bus_addr == ADDR_W'(OFS_CFG));
        wr_k1     = wr_ok && (bus_addr == ADDR_W'(OFS_KEY1));
        wr_k2     = wr_ok && (bus_addr == ADDR_W'(OFS_KEY2));
        start     = wr_cfg && bus_wdata[DATA_W-1] && !run;
        state_clr = rst_req || user_rst || fire;
    end

    // Software-visible configuration, returned to zero by any watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n || state_clr) begin
            cfg_en  <= 1'b0;
            cfg_dly <= '0;
        end else if (wr_cfg) begin
            cfg_en  <= bus_wdata[DATA_W-1];
            cfg_dly <= bus_wdata[DLY_W-1:0];
        end
    end

    // Running state and active delay: change only at a refresh or a start.
    always_ff @(posedge clk) begin
        if (!rst_n || state_clr) begin
            run     <= 1'b0;
            act_dly <= '0;
        end else if (key_good) begin
            run     <= cfg_en;
            act_dly <= cfg_dly;
        end else if (start) begin
            run     <= 1'b1;
            act_dly <= bus_wdata[DLY_W-1:0];
        end
    end

    kwdt_keyseq u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_clr),
        .wr_first  (wr_k1),
        .wr_second (wr_k2),
        .wdata     (bus_wdata),
        .good      (key_good),
        .bad       (key_bad)
    );

    kwdt_period #(.DLY_W(DLY_W)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_clr || key_good || start),
        .run    (run),
        .delay  (act_dly),
        .expire (expire)
    );

    kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_rst  (user_rst),
        .trig_soft (wr_soft && bus_wdata[0]),
        .trig_bad  (run && key_bad),
        .trig_tmo  (expire),
        .req       (rst_req),
        .fire      (fire),
        .cause     (cause)
    );

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CFG)) begin
            bus_rdata[DATA_W-1]  = cfg_en;
            bus_rdata[DLY_W-1:0] = cfg_dly;
        end else if (bus_addr == ADDR_W'(OFS_KEY1)) begin
            bus_rdata[CAUSE_W-1:0] = cause;
        end
    end

    // R5: wrong first key while running raises the request next cycle
    a_r5_bad_key_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !rst_req && !user_rst && run &&
         bus_addr == ADDR_W'(OFS_KEY1) && bus_wdata != KEY_FIRST) |=> rst_req);
    // R7: the watchdog only stops through a refresh or a reset
    a_r7_stop_by_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(key_good || state_clr));
    // R8: soft-reset command yields a request with cause 3
    a_r8_soft_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !rst_req && !user_rst && bus_addr == ADDR_W'(OFS_SOFT) &&
         bus_wdata[0]) |=> (rst_req && cause == CAUSE_SOFT));
    // R6: a stopped watchdog raises nothing without a soft-reset command
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rst_req && !(bus_wr && bus_addr == ADDR_W'(OFS_SOFT) &&
         bus_wdata[0])) |=> !rst_req);
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
    localparam logic [31:0] K1 = 32'hABCD_1234;
    localparam logic [31:0] K2 = 32'h4321_DCBA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_rst = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .user_rst(user_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    function automatic int period_of(input int d);
        return 1 << (d + 1);
    endfunction

    function automatic logic [31:0] not_key(input logic [31:0] k);
        logic [31:0] v = $urandom;
        if (v == k) v = v ^ 32'h1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic refresh();
        wr(4'h8, K1);
        wr(4'hC, K2);
    endtask

    task automatic wait_req(input int maxc, output int n);
        n = 0;
        while (!rst_req && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        while (rst_req) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        hard_reset();

        // R1: reset state and quiet idle
        chk(rst_req == 1'b0, "R1 req after reset", 32'(rst_req), 0);
        rd(4'h8, v); chk(v == 0, "R1 cause after reset", v, 0);
        rd(4'h4, v); chk(v == 0, "R1 cfg after reset", v, 0);
        wait_req(300, n); chk(!rst_req, "R1 idle no request", 32'(n), 300);

        // R2: config readback, then R3 timeout with d=3
        wr(4'h4, 32'h0000_0007);
        rd(4'h4, v); chk(v == 32'h7, "R2 cfg readback", v, 32'h7);
        wr(4'h4, 32'h8000_0003);
        rd(4'h4, v); chk(v == 32'h8000_0003, "R2 cfg enable readback", v, 32'h8000_0003);
        wait_req(1000, n); chk(n == period_of(3), "R3 timeout d=3", 32'(n), 32'(period_of(3)));
        rd(4'h8, v); chk(v == 1, "R2 R3 cause timeout", v, 1);
        n = 1;
        while (rst_req) begin @(negedge clk); if (rst_req) n++; end
        chk(n == 16, "R9 pulse length", 32'(n), 16);
        rd(4'h4, v); chk(v == 0, "R10 cfg cleared after request", v, 0);
        rd(4'h8, v); chk(v == 1, "R10 cause kept", v, 1);
        @(negedge clk);

        // R0 boundary: d=0 gives two cycles
        wr(4'h4, 32'h8000_0000);
        wait_req(100, n); chk(n == 2, "R3 timeout d=0", 32'(n), 2);
        wait_idle();

        // R4: random delays, refresh at a random point, then timeout
        for (int i = 0; i < 6; i++) begin
            int d, w;
            d = $urandom_range(1, 6);
            wr(4'h4, 32'h8000_0000 | 32'(d));
            w = $urandom_range(0, period_of(d) - 3);
            repeat (w) @(negedge clk);
            refresh();
            wait_req(2000, n);
            chk(n == period_of(d), "R4 timeout after refresh", 32'(n), 32'(period_of(d)));
            rd(4'h8, v); chk(v == 1, "R4 cause timeout", v, 1);
            wait_idle();
        end

        // R5: malformed refreshes while running
        for (int i = 0; i < 6; i++) begin
            int k;
            k = $urandom_range(0, 2);
            wr(4'h4, 32'h8000_0005);
            if (k == 0) wr(4'h8, not_key(K1));
            else if (k == 1) begin wr(4'h8, K1); wr(4'hC, not_key(K2)); end
            else wr(4'hC, K2);
            chk(rst_req == 1'b1, "R5 request on bad key", 32'(rst_req), 1);
            rd(4'h8, v); chk(v == 2, "R5 cause bad key", v, 2);
            wait_idle();
        end

        // R9: triggers and writes ignored during the pulse
        wr(4'h4, 32'h8000_0005);
        wr(4'h8, not_key(K1));
        wr(4'h0, 32'h1);
        wr(4'h4, 32'h8000_0002);
        wait_idle();
        rd(4'h8, v); chk(v == 2, "R9 cause kept during pulse", v, 2);
        rd(4'h4, v); chk(v == 0, "R9 cfg write ignored in pulse", v, 0);

        // R6: key writes while stopped
        wr(4'h8, not_key(K1));
        wr(4'hC, not_key(K2));
        wr(4'hC, K2);
        wait_req(50, n); chk(!rst_req, "R6 no request while stopped", 32'(rst_req), 0);
        rd(4'h8, v); chk(v == 2, "R6 cause unchanged", v, 2);

        // R8: soft reset command
        wr(4'h0, 32'hFFFF_FFFE);
        @(negedge clk);
        chk(!rst_req, "R8 bit0 clear ignored", 32'(rst_req), 0);
        wr(4'h0, 32'h0000_0001);
        chk(rst_req == 1'b1, "R8 soft request", 32'(rst_req), 1);
        rd(4'h8, v); chk(v == 3, "R8 cause soft", v, 3);
        wait_idle();

        // R7: clearing enable alone keeps counting
        wr(4'h4, 32'h8000_0004);
        wr(4'h4, 32'h0000_0004);
        wait_req(1000, n); chk(n == period_of(4) - 1, "R7 count continues", 32'(n), 32'(period_of(4) - 1));
        wait_idle();
        // R7: clear enable then refresh stops it
        wr(4'h4, 32'h8000_0003);
        wr(4'h4, 32'h0000_0003);
        refresh();
        wait_req(200, n); chk(!rst_req, "R7 stopped after refresh", 32'(rst_req), 0);
        rd(4'h4, v); chk(v == 32'h3, "R7 cfg after stop", v, 32'h3);

        // R12: delay change while running waits for refresh
        wr(4'h4, 32'h8000_0002);
        wr(4'h4, 32'h8000_0006);
        wait_req(1000, n); chk(n == period_of(2) - 1, "R12 old period kept", 32'(n), 32'(period_of(2) - 1));
        wait_idle();
        wr(4'h4, 32'h8000_0002);
        wr(4'h4, 32'h8000_0005);
        refresh();
        wait_req(1000, n); chk(n == period_of(5), "R12 new period after refresh", 32'(n), 32'(period_of(5)));
        wait_idle();

        // R11: user reset records cause 4 and stops the watchdog
        wr(4'h4, 32'h8000_0003);
        user_rst = 1'b1;
        @(negedge clk);
        user_rst = 1'b0;
        chk(!rst_req, "R11 no request from user reset", 32'(rst_req), 0);
        rd(4'h8, v); chk(v == 4, "R11 cause user", v, 4);
        wait_req(100, n); chk(!rst_req, "R11 watchdog stopped", 32'(rst_req), 0);
        rd(4'h4, v); chk(v == 0, "R11 cfg cleared", v, 0);

        // R10: only the hard reset clears the cause
        @(negedge clk);
        hard_reset();
        rd(4'h8, v); chk(v == 0, "R10 hard reset clears cause", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule